// File: doc/BRIEF.md
# Ethernet Receive Destination Address Filter

This block sits in the receive path of an Ethernet MAC and decides whether each incoming frame is kept. It takes the destination address octets in wire order, one per valid cycle, after a start-of-frame marker. From the six octets it classifies the frame as broadcast, multicast or unicast. It then combines that class with a set of acceptance enables and produces a one-cycle accept or reject strobe.

The local station address sits in two host-writable words. The octets are placed in a fixed, byte-swapped arrangement across the two words. The station address is consulted only for unicast frames, and only while unicast acceptance is on. It plays no part in transmission.

Top module: `rx_da_filter`

## Requirements
- R1: After reset, both address words read zero, `accept_o` and `reject_o` are low, and `class_o` is 0.
- R2: The destination octets map to the address words by wire position. The first octet is the high word bits 7..0, the second is high word bits 15..8, the third is low word bits 7..0, the fourth is low word bits 15..8, the fifth is low word bits 23..16 and the sixth is low word bits 31..24. `reg_sel_i`=0 selects the low word and 1 selects the high word. `reg_rdata_o` returns the selected word combinationally.
- R3: Bits 31..16 of the high word always read zero, and a write to those bits has no effect.
- R4: The decision comes one clock after the cycle that carries the sixth valid octet. In that cycle exactly one of `accept_o` and `reject_o` is high. Each strobe lasts one cycle. No strobe appears at any other time.
- R5: `sof_i` restarts the octet count, and an octet in the same cycle as `sof_i` is the first octet. Octets past the sixth are ignored until the next `sof_i`. Octets that arrive after reset and before the first `sof_i` are also ignored.
- R6: A destination of all ones is class broadcast (`class_o`=2). Any other destination whose first octet has bit 0 set is class multicast (1). All others are class unicast (0). `class_o` updates together with the strobe and holds its value until the next decision.
- R7: `mode_i` bit 0 is the receive enable. When it is 0 at the sixth octet, the frame is rejected.
- R8: When `mode_i` bit 4 (promiscuous) and bit 0 are both set, every frame is accepted.
- R9: A broadcast frame is accepted only if `mode_i` bit 2 is set, unless the frame is accepted promiscuously.
- R10: A multicast frame is accepted only if `mode_i` bit 3 is set, unless the frame is accepted promiscuously.
- R11: A unicast frame is accepted only if `mode_i` bit 1 is set and the destination equals the station address, unless the frame is accepted promiscuously. With bit 1 clear, the station address has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Write strobe for the address words |
| reg_sel_i | input | 1 | Word select: 0 low, 1 high |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data of the selected word |
| mode_i | input | 5 | Enables: bit0 receive, bit1 unicast, bit2 broadcast, bit3 multicast, bit4 promiscuous |
| sof_i | input | 1 | Start of frame, restarts the octet count |
| byte_vld_i | input | 1 | Octet valid |
| byte_i | input | 8 | Destination octet, in wire order |
| accept_o | output | 1 | Frame accepted strobe |
| reject_o | output | 1 | Frame rejected strobe |
| class_o | output | 2 | Class of the last decided frame |

## Verification
The bench builds the block with its default 48-bit address and 32-bit register words. At this size the complete 32-value enable space is small enough to sweep exhaustively. The sweep runs against a broadcast, a multicast, a matching unicast and a mismatching unicast destination, so every gating combination of R7 to R11 is covered. A mismatch in each of the six octet positions in turn checks the byte placement across the two words. Directed octet sequences cover frames with no start marker, trailing octets and a restarted frame.

// File: rtl/rx_da_pkg.sv
package rx_da_pkg;
  typedef enum logic [1:0] {
    CLS_UNI   = 2'd0,
    CLS_MULTI = 2'd1,
    CLS_BCAST = 2'd2
  } frame_class_e;

  localparam int MODE_W    = 5;
  localparam int MODE_EN   = 0;
  localparam int MODE_UNI  = 1;
  localparam int MODE_BC   = 2;
  localparam int MODE_MC   = 3;
  localparam int MODE_PROM = 4;
endpackage

// File: rtl/rx_da_regs.sv
module rx_da_regs #(
  parameter int REG_W  = 32,
  parameter int ADDR_W = 48
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              sel_i,
  input  logic [REG_W-1:0]  wdata_i,
  output logic [REG_W-1:0]  rdata_o,
  output logic [ADDR_W-1:0] station_o
);
  localparam int HI_W = ADDR_W - REG_W;
  localparam int NB   = ADDR_W / 8;

  logic [REG_W-1:0] lo_q;
  logic [HI_W-1:0]  hi_q;
  logic [ADDR_W-1:0] flat;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q <= '0;
      hi_q <= '0;
    end else if (wr_i) begin
      if (sel_i) hi_q <= wdata_i[HI_W-1:0];
      else       lo_q <= wdata_i;
    end
  end

  assign rdata_o = sel_i ? {{(REG_W-HI_W){1'b0}}, hi_q} : lo_q;

  // wire octet j sits at flat byte j: high word first, then low word, LSB first
  assign flat = {lo_q, hi_q};

  for (genvar j = 0; j < NB; j++) begin : g_oct
    assign station_o[ADDR_W-1-8*j -: 8] = flat[8*j +: 8];
  end
endmodule

// File: rtl/rx_da_capture.sv
module rx_da_capture #(
  parameter int ADDR_W = 48
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sof_i,
  input  logic              vld_i,
  input  logic [7:0]        byte_i,
  output logic              last_o,
  output logic [ADDR_W-1:0] da_o
);
  localparam int NB = ADDR_W / 8;
  localparam int CW = $clog2(NB + 1);

  logic [CW-1:0]     cnt_q, cnt_eff;
  logic [ADDR_W-9:0] sh_q;
  logic              take;

  assign cnt_eff = sof_i ? '0 : cnt_q;
  assign take    = vld_i && (cnt_eff < CW'(NB));
  assign last_o  = vld_i && (cnt_eff == CW'(NB - 1));
  // full field presented in the same cycle as the last octet
  assign da_o    = {sh_q, byte_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= CW'(NB);  // idle until first start marker
      sh_q  <= '0;
    end else if (take) begin
      cnt_q <= cnt_eff + 1'b1;
      sh_q  <= {sh_q[ADDR_W-17:0], byte_i};
    end else if (sof_i) begin
      cnt_q <= '0;
    end
  end
endmodule

// File: rtl/rx_da_decide.sv
module rx_da_decide
  import rx_da_pkg::*;
#(
  parameter int ADDR_W = 48
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              last_i,
  input  logic [ADDR_W-1:0] da_i,
  input  logic [ADDR_W-1:0] station_i,
  input  logic [MODE_W-1:0] mode_i,
  output logic              accept_o,
  output logic              reject_o,
  output frame_class_e      class_o
);
  logic         is_bc, is_mc, is_uc, hit;
  frame_class_e cls;

  always_comb begin
    is_bc = &da_i;
    is_mc = da_i[ADDR_W-8] && !is_bc;  // group bit of first octet
    is_uc = !is_bc && !is_mc;
    cls   = is_bc ? CLS_BCAST : (is_mc ? CLS_MULTI : CLS_UNI);
    hit   = mode_i[MODE_EN] &&
            (mode_i[MODE_PROM] ||
             (is_bc && mode_i[MODE_BC]) ||
             (is_mc && mode_i[MODE_MC]) ||
             (is_uc && mode_i[MODE_UNI] && (da_i == station_i)));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      accept_o <= 1'b0;
      reject_o <= 1'b0;
      class_o  <= CLS_UNI;
    end else begin
      accept_o <= last_i && hit;
      reject_o <= last_i && !hit;
      if (last_i) class_o <= cls;
    end
  end
endmodule

// File: rtl/rx_da_filter.sv
module rx_da_filter
  import rx_da_pkg::*;
#(
  parameter int REG_W  = 32,
  parameter int ADDR_W = 48
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_wr_i,
  input  logic              reg_sel_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  output logic [REG_W-1:0]  reg_rdata_o,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              sof_i,
  input  logic              byte_vld_i,
  input  logic [7:0]        byte_i,
  output logic              accept_o,
  output logic              reject_o,
  output logic [1:0]        class_o
);
  logic [ADDR_W-1:0] station;
  logic [ADDR_W-1:0] da;
  logic              da_last;
  frame_class_e      cls;

  rx_da_regs #(.REG_W(REG_W), .ADDR_W(ADDR_W)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (reg_wr_i),
    .sel_i    (reg_sel_i),
    .wdata_i  (reg_wdata_i),
    .rdata_o  (reg_rdata_o),
    .station_o(station)
  );

  rx_da_capture #(.ADDR_W(ADDR_W)) u_cap (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .sof_i (sof_i),
    .vld_i (byte_vld_i),
    .byte_i(byte_i),
    .last_o(da_last),
    .da_o  (da)
  );

  rx_da_decide #(.ADDR_W(ADDR_W)) u_dec (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .last_i   (da_last),
    .da_i     (da),
    .station_i(station),
    .mode_i   (mode_i),
    .accept_o (accept_o),
    .reject_o (reject_o),
    .class_o  (cls)
  );

  assign class_o = cls;
endmodule

// File: rtl/rx_da_filter_chk.sv
module rx_da_filter_chk #(
  parameter int REG_W = 32,
  parameter int HI_W  = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [4:0]       mode_i,
  input logic             da_last_i,
  input logic             accept_i,
  input logic             reject_i,
  input logic             reg_sel_i,
  input logic [REG_W-1:0] reg_rdata_i
);
  AST_ONE_RESULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(accept_i && reject_i)); // R4
  AST_RESULT_AFTER_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    da_last_i |=> (accept_i || reject_i)); // R4
  AST_NO_SPURIOUS_RESULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept_i || reject_i) |-> $past(da_last_i)); // R4
  AST_DISABLED_REJECTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (da_last_i && !mode_i[0]) |=> reject_i); // R7
  AST_PROMISC_ACCEPTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (da_last_i && mode_i[0] && mode_i[4]) |=> accept_i); // R8
  AST_HI_UPPER_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_sel_i |-> (reg_rdata_i[REG_W-1:HI_W] == '0)); // R3
endmodule

bind rx_da_filter rx_da_filter_chk #(.REG_W(REG_W), .HI_W(ADDR_W - REG_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .mode_i     (mode_i),
  .da_last_i  (da_last),
  .accept_i   (accept_o),
  .reject_i   (reject_o),
  .reg_sel_i  (reg_sel_i),
  .reg_rdata_i(reg_rdata_o)
);

// File: tb/rx_da_filter_test.sv
`timescale 1ns/1ps
module rx_da_filter_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_wr_i = 1'b0, reg_sel_i = 1'b0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic [4:0]  mode_i = '0;
  logic        sof_i = 1'b0, byte_vld_i = 1'b0;
  logic [7:0]  byte_i = '0;
  logic        accept_o, reject_o;
  logic [1:0]  class_o;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 0;

  localparam logic [47:0] STATION = 48'h02_12_34_56_78_9A;
  localparam logic [47:0] BCAST   = 48'hFFFF_FFFF_FFFF;
  localparam logic [47:0] MCAST   = 48'h01_00_5E_00_00_FB;
  localparam logic [47:0] OTHER   = 48'h00_AA_BB_CC_DD_EE;

  always #2 clk = ~clk;

  rx_da_filter uut (
    .clk_i(clk), .rst_ni(rst_ni),
    .reg_wr_i(reg_wr_i), .reg_sel_i(reg_sel_i), .reg_wdata_i(reg_wdata_i),
    .reg_rdata_o(reg_rdata_o), .mode_i(mode_i), .sof_i(sof_i),
    .byte_vld_i(byte_vld_i), .byte_i(byte_i),
    .accept_o(accept_o), .reject_o(reject_o), .class_o(class_o)
  );

  task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic exp_hit(logic [47:0] da, logic [4:0] m);
    logic bc, mc, uc;
    bc = (da == BCAST);
    mc = !bc && da[40];
    uc = !bc && !da[40];
    return m[0] && (m[4] || (bc && m[2]) || (mc && m[3]) ||
                    (uc && m[1] && (da == STATION)));
  endfunction

  function automatic logic [1:0] exp_cls(logic [47:0] da);
    if (da == BCAST) return 2'd2;
    if (da[40])      return 2'd1;
    return 2'd0;
  endfunction

  task automatic send_byte(logic [7:0] b, logic s);
    @(negedge clk);
    byte_vld_i = 1'b1; byte_i = b; sof_i = s;
  endtask

  task automatic idle();
    @(negedge clk);
    byte_vld_i = 1'b0; sof_i = 1'b0;
  endtask

  task automatic wr(logic sel, logic [31:0] d);
    @(negedge clk);
    reg_wr_i = 1'b1; reg_sel_i = sel; reg_wdata_i = d;
    @(negedge clk);
    reg_wr_i = 1'b0;
  endtask

  task automatic run_frame(logic [47:0] da, logic [4:0] m, string req);
    logic h;
    h = exp_hit(da, m);
    mode_i = m;
    for (int i = 0; i < 6; i++) send_byte(da[47-8*i -: 8], i == 0);
    idle();
    check(req, "accept", accept_o, h);
    check("R4", "reject", reject_o, !h);
    check("R6", "class", class_o, exp_cls(da));
    @(negedge clk);
    check("R4", "pulse end", {accept_o, reject_o}, 2'b00);
    check("R6", "class hold", class_o, exp_cls(da));
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1", "accept", accept_o, 1'b0);
    check("R1", "reject", reject_o, 1'b0);
    check("R1", "class", class_o, 2'd0);
    reg_sel_i = 1'b0; #0.1;
    check("R1", "low word", reg_rdata_o, 32'h0);
    reg_sel_i = 1'b1; #0.1;
    check("R1", "high word", reg_rdata_o, 32'h0);

    // R5 octets before any start marker are ignored
    mode_i = 5'b10001;
    for (int i = 0; i < 6; i++) send_byte(8'hFF, 1'b0);
    idle();
    check("R5", "no sof strobe", {accept_o, reject_o}, 2'b00);
    @(negedge clk);
    check("R5", "no sof strobe later", {accept_o, reject_o}, 2'b00);

    // R2 / R3 register mapping
    wr(1'b1, {16'hDEAD, STATION[39:32], STATION[47:40]});
    wr(1'b0, {STATION[7:0], STATION[15:8], STATION[23:16], STATION[31:24]});
    reg_sel_i = 1'b1; #0.1;
    check("R3", "high word upper zero", reg_rdata_o, {16'h0, STATION[39:32], STATION[47:40]});
    reg_sel_i = 1'b0; #0.1;
    check("R2", "low word", reg_rdata_o, 32'h9A78_5634);
    run_frame(STATION, 5'b00011, "R2");
    for (int k = 0; k < 6; k++) begin
      logic [47:0] d;
      d = STATION ^ (48'h02 << (8*k));  // flip bit 1 of one octet, group bit untouched
      run_frame(d, 5'b00011, "R2");
    end

    // R7..R11 exhaustive over enables
    for (int m = 0; m < 32; m++) begin
      logic [47:0] set [4];
      set[0] = BCAST; set[1] = MCAST; set[2] = STATION; set[3] = OTHER;
      for (int a = 0; a < 4; a++) begin
        string r;
        if (!m[0])     r = "R7";
        else if (m[4]) r = "R8";
        else if (a == 0) r = "R9";
        else if (a == 1) r = "R10";
        else             r = "R11";
        run_frame(set[a], 5'(m), r);
      end
    end

    // R5 trailing octets ignored
    run_frame(OTHER, 5'b10001, "R8");
    for (int i = 0; i < 6; i++) send_byte(8'h55, 1'b0);
    idle();
    check("R5", "trailing octets", {accept_o, reject_o}, 2'b00);
    @(negedge clk);
    check("R5", "trailing octets later", {accept_o, reject_o}, 2'b00);

    // R5 restart mid-field
    mode_i = 5'b00011;
    send_byte(8'hFF, 1'b1); send_byte(8'hFF, 1'b0); send_byte(8'hFF, 1'b0);
    for (int i = 0; i < 6; i++) send_byte(STATION[47-8*i -: 8], i == 0);
    idle();
    check("R5", "restart accept", accept_o, 1'b1);
    check("R5", "restart class", class_o, 2'd0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule